// File: doc/BRIEF.md
# Multithread Commit Thread Selector

This block decides which hardware thread may retire the instruction at the head of its reorder buffer in the current commit slot. For every thread it receives a commit-state code, a flag saying the head entry is ready, a flag saying the buffer is empty, and the sequence number of the head entry. A two-bit policy input selects between a rotating priority list and an oldest-first comparison. The block returns a thread index together with a valid flag.

The selection itself is combinational, so the commit stage can read a result in the same cycle it presents the per-thread status. The rotating policy keeps a registered priority list of thread indices. The commit stage pulses `pick_i` when it consumes a selection, and the chosen thread then moves to the back of that list at the next clock edge. When the block is built for a single thread, it reduces to a state check on that one thread.

Top module: `commit_thread_sel`

## Requirements
- R1: Commit-state codes are 3 bits per thread, with thread t in bits [3t+2:3t]: 0 idle, 1 running, 2 squashing, 3 trap pending, 4 fetch-trap pending, 5 to 7 unused. Only codes 0, 1 and 4 make a thread eligible. A thread with any other code is never selected.
- R2: With policy code 0 (rotating), the block scans its priority list from the front and selects the first thread that is eligible and has `head_ready_i` set. After reset the list holds the thread indices in ascending order.
- R3: With policy code 0, a valid selection and `pick_i` high at a clock edge, the selected thread moves to the tail of the list and the other entries keep their relative order. Without `pick_i`, or under any other policy code, the list does not change.
- R4: With policy code 1 (oldest-first), the block selects, among threads that are eligible, have a ready head and have `rob_empty_i` low, the thread whose head sequence number is smallest. The sequence number of thread t is in `head_seq_i[SEQ_W*t +: SEQ_W]`.
- R5: Under oldest-first, equal sequence numbers resolve toward the lower thread index.
- R6: Policy codes 2 and 3 behave exactly like code 1.
- R7: When no thread qualifies under the active policy, `valid_o` is low and `thread_o` is 0.
- R8: With NUM_THREADS = 1, thread 0 is selected whenever its state is eligible, whatever its ready and empty flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | 0 rotating, 1 to 3 oldest-first |
| pick_i | input | 1 | Selection consumed this cycle |
| state_i | input | 3*NUM_THREADS | Per-thread commit-state codes |
| head_ready_i | input | NUM_THREADS | Head entry ready to retire |
| rob_empty_i | input | NUM_THREADS | Reorder buffer empty |
| head_seq_i | input | SEQ_W*NUM_THREADS | Head sequence numbers |
| valid_o | output | 1 | A thread was selected |
| thread_o | output | IDX_W | Selected thread index |

## Verification
The oldest-first comparison is driven with distinct sequence numbers, with some threads masked by an empty buffer, an unready head or an ineligible state, and with tied sequence numbers. These cases separate a true minimum search from a first-ready search and check the tie rule. The rotating policy is driven with a thread that is blocked first and released later. With that sequence, move-to-tail ordering produces a different result from a plain rotating pointer. Held cycles without `pick_i`, and cycles with `pick_i` under oldest-first, show that the list stays unchanged when it should. A one-thread instance checks that readiness is ignored there.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    CS_IDLE   = 3'd0,
    CS_RUN    = 3'd1,
    CS_SQUASH = 3'd2,
    CS_TRAP   = 3'd3,
    CS_FTRAP  = 3'd4
  } cstate_e;

  localparam int unsigned STATE_W = 3;
  localparam logic [1:0]  POL_RR  = 2'd0;

  function automatic logic state_eligible(input logic [STATE_W-1:0] s);
    return (s == CS_IDLE) || (s == CS_RUN) || (s == CS_FTRAP);
  endfunction
endpackage

// File: rtl/csel_eligible.sv
module csel_eligible
  import csel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*STATE_W-1:0] state_i,
  output logic [NUM_THREADS-1:0]         elig_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_dec
    assign elig_o[t] = state_eligible(state_i[t*STATE_W +: STATE_W]);
  end
endmodule

// File: rtl/csel_rr_list.sv
module csel_rr_list #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned IDX_W       = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] cand_i,
  input  logic                   adv_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [IDX_W-1:0] list_q [NUM_THREADS];
  logic [IDX_W-1:0] list_d [NUM_THREADS];
  logic [IDX_W-1:0] pos;
  logic             hit;

  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!hit && cand_i[list_q[p]]) begin
        hit = 1'b1;
        pos = IDX_W'(p);
      end
    end
  end

  assign valid_o = hit;
  assign idx_o   = hit ? list_q[pos] : '0;

  // remove chosen entry, close the gap, append at tail
  always_comb begin
    for (int p = 0; p < NUM_THREADS; p++) list_d[p] = list_q[p];
    if (adv_i && hit) begin
      for (int p = 0; p < NUM_THREADS-1; p++) begin
        if (IDX_W'(p) >= pos) list_d[p] = list_q[p+1];
      end
      list_d[NUM_THREADS-1] = list_q[pos];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_THREADS; p++) list_q[p] <= IDX_W'(p);
    end else begin
      for (int p = 0; p < NUM_THREADS; p++) list_q[p] <= list_d[p];
    end
  end
endmodule

// File: rtl/csel_oldest.sv
module csel_oldest #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned IDX_W       = 2
) (
  input  logic [NUM_THREADS-1:0]       cand_i,
  input  logic [NUM_THREADS*SEQ_W-1:0] seq_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [SEQ_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (cand_i[t] && (!valid_o || seq_i[t*SEQ_W +: SEQ_W] < best)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(t);
        best    = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import csel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  localparam int unsigned IDX_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   policy_i,
  input  logic                         pick_i,
  input  logic [NUM_THREADS*3-1:0]     state_i,
  input  logic [NUM_THREADS-1:0]       head_ready_i,
  input  logic [NUM_THREADS-1:0]       rob_empty_i,
  input  logic [NUM_THREADS*SEQ_W-1:0] head_seq_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             thread_o
);
  logic [NUM_THREADS-1:0] elig;

  csel_eligible #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .state_i (state_i),
    .elig_o  (elig)
  );

  if (NUM_THREADS == 1) begin : g_single
    assign valid_o  = elig[0];
    assign thread_o = '0;
  end else begin : g_multi
    logic             use_rr;
    logic             rr_valid, old_valid;
    logic [IDX_W-1:0] rr_idx, old_idx;

    assign use_rr = (policy_i == POL_RR);

    csel_rr_list #(.NUM_THREADS(NUM_THREADS), .IDX_W(IDX_W)) u_rr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cand_i  (elig & head_ready_i),
      .adv_i   (use_rr & pick_i),
      .valid_o (rr_valid),
      .idx_o   (rr_idx)
    );

    csel_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_old (
      .cand_i  (elig & head_ready_i & ~rob_empty_i),
      .seq_i   (head_seq_i),
      .valid_o (old_valid),
      .idx_o   (old_idx)
    );

    assign valid_o  = use_rr ? rr_valid : old_valid;
    assign thread_o = use_rr ? rr_idx   : old_idx;
  end
endmodule

// File: rtl/commit_thread_sel_checker.sv
module commit_thread_sel_checker #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned IDX_W       = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   policy_i,
  input logic [NUM_THREADS*3-1:0]     state_i,
  input logic [NUM_THREADS-1:0]       head_ready_i,
  input logic [NUM_THREADS-1:0]       rob_empty_i,
  input logic [NUM_THREADS*SEQ_W-1:0] head_seq_i,
  input logic                         valid_o,
  input logic [IDX_W-1:0]             thread_o
);
  logic [2:0]       sel_state;
  logic             sel_ok, any_ready_elig, older_seen, multi;
  logic [SEQ_W-1:0] sel_seq;

  assign multi     = (NUM_THREADS > 1);
  assign sel_state = state_i[thread_o*3 +: 3];
  assign sel_seq   = head_seq_i[thread_o*SEQ_W +: SEQ_W];
  assign sel_ok    = (sel_state == 3'd0) || (sel_state == 3'd1) || (sel_state == 3'd4);

  always_comb begin
    any_ready_elig = 1'b0;
    older_seen     = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [2:0] s;
      logic       q;
      s = state_i[t*3 +: 3];
      q = ((s == 3'd0) || (s == 3'd1) || (s == 3'd4)) && head_ready_i[t];
      if (q) any_ready_elig = 1'b1;
      if (q && !rob_empty_i[t] && head_seq_i[t*SEQ_W +: SEQ_W] < sel_seq) older_seen = 1'b1;
    end
  end

  assert_sel_eligible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sel_ok);

  assert_sel_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && multi) |-> head_ready_i[thread_o]);

  assert_oldest_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && multi && policy_i != 2'd0) |-> (!older_seen && !rob_empty_i[thread_o]));

  assert_none_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi && !any_ready_elig) |-> (!valid_o && thread_o == '0));

  assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(thread_o) < NUM_THREADS));
endmodule

bind commit_thread_sel commit_thread_sel_checker #(
  .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i), .state_i(state_i),
  .head_ready_i(head_ready_i), .rob_empty_i(rob_empty_i), .head_seq_i(head_seq_i),
  .valid_o(valid_o), .thread_o(thread_o)
);

// File: tb/commit_thread_sel_bench.sv
module commit_thread_sel_bench;
  localparam int NT = 4;
  localparam int SW = 8;
  localparam logic [2:0] ID = 3'd0, RN = 3'd1, SQ = 3'd2, TP = 3'd3, FT = 3'd4;

  typedef struct packed {
    logic [1:0]    pol;
    logic [11:0]   st;
    logic [3:0]    rdy;
    logic [3:0]    emp;
    logic [31:0]   seq;
    logic          ev;
    logic [1:0]    ei;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd1, {RN,RN,RN,RN}, 4'b1111, 4'b0000, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd1}, // R4
    '{2'd1, {RN,RN,RN,RN}, 4'b1111, 4'b0010, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd3}, // R4 empty masks
    '{2'd1, {SQ,RN,RN,RN}, 4'b1111, 4'b0010, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd2}, // R1 squash
    '{2'd1, {RN,RN,RN,RN}, 4'b1111, 4'b0000, {8'd5,8'd5,8'd9,8'd5},     1'b1, 2'd0}, // R5 tie
    '{2'd1, {RN,RN,RN,RN}, 4'b1110, 4'b0000, {8'd5,8'd5,8'd9,8'd5},     1'b1, 2'd2}, // R5 tie not ready
    '{2'd1, {RN,RN,RN,RN}, 4'b0000, 4'b0000, {8'd5,8'd5,8'd9,8'd5},     1'b0, 2'd0}, // R7
    '{2'd2, {RN,RN,RN,RN}, 4'b1111, 4'b0000, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd1}, // R6
    '{2'd3, {RN,RN,RN,RN}, 4'b1111, 4'b0000, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd1}, // R6
    '{2'd1, {ID,RN,FT,RN}, 4'b1111, 4'b0000, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd1}, // R1 ftrap ok
    '{2'd1, {ID,RN,TP,RN}, 4'b1111, 4'b0000, {8'd20,8'd30,8'd10,8'd40}, 1'b1, 2'd3}  // R1 trap
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pol = '0;
  logic pick = 1'b0;
  logic [NT*3-1:0] st = '0;
  logic [NT-1:0] rdy = '0, emp = '0;
  logic [NT*SW-1:0] seq = '0;
  logic v;
  logic [1:0] ix;

  logic [2:0] st1 = '0;
  logic rdy1 = 1'b0, emp1 = 1'b0;
  logic [SW-1:0] seq1 = '0;
  logic v1;
  logic ix1;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) u_commit_thread_sel (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .pick_i(pick), .state_i(st),
    .head_ready_i(rdy), .rob_empty_i(emp), .head_seq_i(seq), .valid_o(v), .thread_o(ix));

  commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u_commit_thread_sel_one (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .pick_i(pick), .state_i(st1),
    .head_ready_i(rdy1), .rob_empty_i(emp1), .head_seq_i(seq1), .valid_o(v1), .thread_o(ix1));

  task automatic chk(string req, logic av, logic [1:0] ai, logic exv, logic [1:0] exi);
    checks++;
    if (av !== exv || (exv && ai !== exi) || (!exv && ai !== 2'd0)) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d", req, av, ai, exv, exi);
    end
  endtask

  // drive at negedge, check, hold through next posedge
  task automatic step(logic [1:0] p, logic pk, logic [11:0] s, logic [3:0] r,
                      logic [3:0] e, logic [31:0] q, string req, logic exv, logic [1:0] exi);
    @(negedge clk);
    pol = p; pick = pk; st = s; rdy = r; emp = e; seq = q;
    #1 chk(req, v, ix, exv, exi);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R7 reset idle not ready", v, ix, 1'b0, 2'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++)
      step(VECS[k].pol, 1'b0, VECS[k].st, VECS[k].rdy, VECS[k].emp, VECS[k].seq,
           $sformatf("R4 vector %0d", k), VECS[k].ev, VECS[k].ei);

    // R2 list order after reset
    step(2'd0, 1'b0, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R2 reset list front", 1'b1, 2'd0);
    step(2'd0, 1'b0, {RN,RN,RN,RN}, 4'b1110, 4'b0, '0, "R2 skip not ready", 1'b1, 2'd1);
    // R3 move to tail: list 0123 -> 0231 -> 2310 -> 3102 -> 1023 -> 0231
    step(2'd0, 1'b1, {RN,RN,RN,TP}, 4'b1111, 4'b0, '0, "R1 trap skipped rr", 1'b1, 2'd1);
    step(2'd0, 1'b1, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 tail order a", 1'b1, 2'd0);
    step(2'd0, 1'b1, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 tail order b", 1'b1, 2'd2);
    step(2'd0, 1'b1, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 tail order c", 1'b1, 2'd3);
    step(2'd0, 1'b1, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 tail order d", 1'b1, 2'd1);
    step(2'd0, 1'b0, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 no pick hold a", 1'b1, 2'd0);
    step(2'd0, 1'b0, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 no pick hold b", 1'b1, 2'd0);
    step(2'd1, 1'b1, {RN,RN,RN,RN}, 4'b1111, 4'b0, {8'd1,8'd7,8'd8,8'd9}, "R4 oldest pick", 1'b1, 2'd3);
    step(2'd1, 1'b1, {RN,RN,RN,RN}, 4'b1111, 4'b0, {8'd1,8'd7,8'd8,8'd9}, "R4 oldest pick again", 1'b1, 2'd3);
    step(2'd0, 1'b0, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 oldest leaves list", 1'b1, 2'd0);
    step(2'd0, 1'b1, {RN,RN,RN,RN}, 4'b0000, 4'b0, '0, "R7 rr none ready", 1'b0, 2'd0);
    step(2'd0, 1'b0, {RN,RN,RN,RN}, 4'b1111, 4'b0, '0, "R3 invalid pick no move", 1'b1, 2'd0);

    // R8 single thread
    @(negedge clk); st1 = RN; rdy1 = 1'b0; emp1 = 1'b1;
    #1 chk("R8 single ready ignored", v1, {1'b0, ix1}, 1'b1, 2'd0);
    @(negedge clk); st1 = SQ; rdy1 = 1'b1; emp1 = 1'b0;
    #1 chk("R8 single squash", v1, {1'b0, ix1}, 1'b0, 2'd0);
    @(negedge clk); st1 = ID;
    #1 chk("R8 single idle", v1, {1'b0, ix1}, 1'b1, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule